// File: doc/BRIEF.md
# Ethernet receive status record generator

The block watches a received Ethernet frame that arrives one byte per cycle, with markers for the first byte, the last byte and error results. While the frame arrives it keeps the destination address, the four header bytes that follow the two addresses, and a saturating byte count. It also writes the frame bytes into a local buffer. When the last byte arrives it builds a six-word, 32-bit status record and sends it on a status stream with valid/ready handshaking.

After the final status word has been accepted, the buffered bytes go out on a separate 32-bit data stream. Bytes are packed little-endian, and a byte strobe qualifies the final word. CRC checking and error detection are done upstream; their results arrive with the last byte. While a record or its data is still pending, the block ignores new input. A downstream DMA-style consumer can therefore read the record before it moves the payload.

Top module: `rx_status_gen`

## Requirements
- R1: Every record is six words sent in the order 0 to 5, with `sts_last` high only on word 5. Word 0 is 0x5000_0000, with the tag 0x5 in bits 31:28. All bits not assigned by R2 to R6 are zero.
- R2: The destination address comes from frame bytes 0 to 5. Byte 0 is placed in the least significant byte of a 48-bit value. Word 2 is bits 31:0 of that value, and word 1 bits 15:0 are bits 47:32. Bytes 00 11 22 33 44 55 give word 2 = 0x33221100 and word 1 = 0x00005544.
- R3: Word 3 bits 24:11 hold the frame length in bytes. The length saturates at 16383.
- R4: Word 3 holds five flags:
  - bit 10: bit 0 of frame byte 0 (multicast);
  - bit 9: all 48 address bits are one (broadcast);
  - bit 8: `rx_fcs_err`;
  - bit 7: `rx_fcs_err` OR `rx_other_err`;
  - bit 6: the inverse of bit 7.
  
  Both error inputs are sampled on the last-byte beat.
- R5: Word 4 bits 31:24 hold frame byte 12 and bits 23:16 hold byte 13. Word 5 bits 31:24 hold byte 14 and bits 23:16 hold byte 15. A byte that was not received reads as zero.
- R6: Word 5 bits 15:0 hold the number of bytes sent on the data stream. That number is the smaller of the frame length and the buffer capacity `CAP_BYTES` (1024 by default).
- R7: Data byte k goes in word k/4, at bits 8*(k%4)+7 down to 8*(k%4). `dat_last` is high on the final word only.
  - Every non-final word has strobe 1111.
  - The final word has strobe 1111, 0001, 0011 or 0111 when 0, 1, 2 or 3 bytes remain, counted modulo 4.
  - Lanes with a cleared strobe bit carry zero.
- R8: `dat_valid` stays low for a frame until word 5 of that frame's record has been accepted. The two valids are never high together.
- R9: While a valid is high and its ready is low, the valid and the word on that stream hold steady.
- R10: Input is ignored from the last-byte beat through the cycle in which the final data word is accepted. This includes a start marker on that acceptance cycle. When idle, bytes without a start marker are also ignored and produce no output.
- R11: After reset, `sts_valid` and `dat_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_fcs_err | input | 1 | Frame check sequence failed (valid with rx_eof) |
| rx_other_err | input | 1 | Any other reception error (valid with rx_eof) |
| sts_valid | output | 1 | Status word valid |
| sts_ready | input | 1 | Status consumer ready |
| sts_data | output | 32 | Status word |
| sts_last | output | 1 | Final status word (word 5) |
| dat_valid | output | 1 | Data word valid |
| dat_ready | input | 1 | Data consumer ready |
| dat_data | output | 32 | Packed frame bytes |
| dat_strb | output | 4 | Byte strobe, low lanes first |
| dat_last | output | 1 | Final data word of the frame |

## Verification
Two events can land in the same cycle: acceptance of a frame's final data word, which frees the block, and the start marker of the next frame. The bench holds data ready low until the final word is presented. It then raises ready in the same cycle that it drives the next frame's first byte. The colliding frame must produce no status record at all, and a frame sent afterwards must produce a correct record and payload. Random backpressure on both streams also makes status acceptance and data release fall on adjacent edges. The order between the streams is checked on every accepted data beat.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    localparam logic [13:0] LEN_SAT   = 14'h3FFF;
    localparam logic [3:0]  TAG_VALUE = 4'h5;
    localparam int          NUM_WORDS = 6;

    typedef enum logic [1:0] {C_IDLE, C_RECV, C_HOLD} cap_state_e;
    typedef enum logic [1:0] {E_IDLE, E_STS, E_DAT}   emit_state_e;

    typedef struct packed {
        logic [47:0] dst;
        logic [15:0] tl;
        logic [15:0] vtag;
        logic [13:0] len;
        logic        fcs_err;
        logic        other_err;
        logic [15:0] nbytes;
    } rec_t;

    function automatic logic [31:0] status_word(input rec_t r, input logic [2:0] idx);
        logic [31:0] w;
        logic        bad;
        w   = '0;
        bad = r.fcs_err | r.other_err;
        case (idx)
            3'd0: w[31:28] = TAG_VALUE;
            3'd1: w[15:0]  = r.dst[47:32];
            3'd2: w        = r.dst[31:0];
            3'd3: begin
                w[24:11] = r.len;
                w[10]    = r.dst[0];
                w[9]     = &r.dst;
                w[8]     = r.fcs_err;
                w[7]     = bad;
                w[6]     = ~bad;
            end
            3'd4: w[31:16] = r.tl;
            3'd5: w        = {r.vtag, r.nbytes};
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rsg_capture.sv
module rsg_capture
    import rsg_pkg::*;
#(
    parameter int CAP_BYTES = 1024,
    localparam int AW = $clog2(CAP_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic          in_fcs_err,
    input  logic          in_other_err,
    input  logic          release_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          done_o,
    output rec_t          rec_o
);

    localparam logic [14:0] CAP15 = 15'(CAP_BYTES);

    typedef struct packed {
        cap_state_e  st;
        logic [13:0] cnt;
        rec_t        rec;
        logic        done;
    } cap_t;

    cap_t        cap_d, cap_q;
    logic        take;
    logic [13:0] idx;
    logic [13:0] nxt;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = 1'b0;
        wr_en_o    = 1'b0;
        wr_addr_o  = '0;
        take = in_valid && ((cap_q.st == C_IDLE && in_sof) || cap_q.st == C_RECV);
        idx  = in_sof ? 14'd0 : cap_q.cnt;
        nxt  = (idx == LEN_SAT) ? LEN_SAT : idx + 14'd1;
        if (take) begin
            if (in_sof) begin
                cap_d.rec = '0;
            end
            for (int k = 0; k < 6; k++) begin
                if (idx == 14'(k)) begin
                    cap_d.rec.dst[8*k +: 8] = in_data;
                end
            end
            if (idx == 14'd12) cap_d.rec.tl[15:8]   = in_data;
            if (idx == 14'd13) cap_d.rec.tl[7:0]    = in_data;
            if (idx == 14'd14) cap_d.rec.vtag[15:8] = in_data;
            if (idx == 14'd15) cap_d.rec.vtag[7:0]  = in_data;
            cap_d.cnt     = nxt;
            cap_d.rec.len = nxt;
            cap_d.st      = C_RECV;
            wr_en_o       = ({1'b0, idx} < CAP15);
            wr_addr_o     = idx[AW-1:0];
            if (in_eof) begin
                cap_d.st            = C_HOLD;
                cap_d.done          = 1'b1;
                cap_d.rec.fcs_err   = in_fcs_err;
                cap_d.rec.other_err = in_other_err;
                cap_d.rec.nbytes    = ({1'b0, nxt} > CAP15) ? {1'b0, CAP15} : {2'b00, nxt};
            end
        end
        if (cap_q.st == C_HOLD && release_i) begin
            cap_d.st = C_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q.st   <= C_IDLE;
            cap_q.cnt  <= '0;
            cap_q.rec  <= '0;
            cap_q.done <= 1'b0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wr_data_o = in_data;
    assign done_o    = cap_q.done;
    assign rec_o     = cap_q.rec;

    AST_LEN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.st == C_RECV && !in_sof) |=> (cap_q.cnt >= $past(cap_q.cnt))) else $error("length wrapped"); // R3
    AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.st == C_HOLD && !release_i) |=> cap_q.st == C_HOLD) else $error("left hold early"); // R10

endmodule

// File: rtl/rsg_buffer.sv
module rsg_buffer #(
    parameter int CAP_BYTES = 1024,
    localparam int AW  = $clog2(CAP_BYTES),
    localparam int WAW = AW - 2
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [7:0]     wr_data,
    input  logic [WAW-1:0] rd_addr,
    output logic [31:0]    rd_word
);

    localparam int WORDS = CAP_BYTES / 4;

    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr[AW-1:2]][8*wr_addr[1:0] +: 8] <= wr_data;
        end
    end

    assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/rsg_emitter.sv
module rsg_emitter
    import rsg_pkg::*;
#(
    parameter int CAP_BYTES = 1024,
    localparam int WAW = $clog2(CAP_BYTES) - 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  rec_t           rec_i,
    output logic [WAW-1:0] rd_addr_o,
    input  logic [31:0]    rd_word_i,
    output logic           sts_valid_o,
    input  logic           sts_ready_i,
    output logic [31:0]    sts_data_o,
    output logic           sts_last_o,
    output logic           dat_valid_o,
    input  logic           dat_ready_i,
    output logic [31:0]    dat_data_o,
    output logic [3:0]     dat_strb_o,
    output logic           dat_last_o,
    output logic           release_o,
    output logic           busy_o
);

    typedef struct packed {
        emit_state_e    st;
        logic [2:0]     widx;
        logic [WAW-1:0] rptr;
        rec_t           rec;
    } emit_t;

    emit_t       em_d, em_q;
    logic [15:0] last_ptr;
    logic        is_last;
    logic [3:0]  tail_mask;

    always_comb begin
        last_ptr = (em_q.rec.nbytes - 16'd1) >> 2;
        is_last  = ({{(16-WAW){1'b0}}, em_q.rptr} == last_ptr);
        case (em_q.rec.nbytes[1:0])
            2'd1:    tail_mask = 4'b0001;
            2'd2:    tail_mask = 4'b0011;
            2'd3:    tail_mask = 4'b0111;
            default: tail_mask = 4'b1111;
        endcase
    end

    always_comb begin
        em_d        = em_q;
        sts_valid_o = 1'b0;
        sts_data_o  = '0;
        sts_last_o  = 1'b0;
        dat_valid_o = 1'b0;
        dat_data_o  = '0;
        dat_strb_o  = '0;
        dat_last_o  = 1'b0;
        release_o   = 1'b0;
        case (em_q.st)
            E_IDLE: begin
                if (start_i) begin
                    em_d.st   = E_STS;
                    em_d.widx = '0;
                    em_d.rec  = rec_i;
                end
            end
            E_STS: begin
                sts_valid_o = 1'b1;
                sts_data_o  = status_word(em_q.rec, em_q.widx);
                sts_last_o  = (em_q.widx == 3'(NUM_WORDS - 1));
                if (sts_ready_i) begin
                    if (sts_last_o) begin
                        em_d.st   = E_DAT;
                        em_d.rptr = '0;
                    end else begin
                        em_d.widx = em_q.widx + 3'd1;
                    end
                end
            end
            E_DAT: begin
                dat_valid_o = 1'b1;
                dat_last_o  = is_last;
                dat_strb_o  = is_last ? tail_mask : 4'hF;
                for (int b = 0; b < 4; b++) begin
                    dat_data_o[8*b +: 8] = dat_strb_o[b] ? rd_word_i[8*b +: 8] : 8'h00;
                end
                if (dat_ready_i) begin
                    if (is_last) begin
                        em_d.st   = E_IDLE;
                        release_o = 1'b1;
                    end else begin
                        em_d.rptr = em_q.rptr + 1'b1;
                    end
                end
            end
            default: em_d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            em_q.st   <= E_IDLE;
            em_q.widx <= '0;
            em_q.rptr <= '0;
            em_q.rec  <= '0;
        end else begin
            em_q <= em_d;
        end
    end

    assign rd_addr_o = em_q.rptr;
    assign busy_o    = (em_q.st != E_IDLE);

    AST_STS_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid_o && !sts_ready_i) |=> (sts_valid_o && $stable(sts_data_o) && $stable(sts_last_o))) else $error("status moved under stall"); // R9
    AST_DAT_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid_o && !dat_ready_i) |=> (dat_valid_o && $stable(dat_data_o) && $stable(dat_strb_o))) else $error("data moved under stall"); // R9
    AST_DATA_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_valid_o) |-> $past(sts_valid_o && sts_ready_i && sts_last_o)) else $error("data before status"); // R8
    AST_STREAMS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sts_valid_o && dat_valid_o)) else $error("both valids high"); // R8
    AST_SIX_WORDS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid_o && sts_ready_i && sts_last_o) |=> !sts_valid_o) else $error("status past word 5"); // R1
    AST_FULL_STRB_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid_o && !dat_last_o) |-> dat_strb_o == 4'hF) else $error("partial strobe mid frame"); // R7

endmodule

// File: rtl/rx_status_gen.sv
module rx_status_gen
    import rsg_pkg::*;
#(
    parameter int CAP_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_fcs_err,
    input  logic        rx_other_err,
    output logic        sts_valid,
    input  logic        sts_ready,
    output logic [31:0] sts_data,
    output logic        sts_last,
    output logic        dat_valid,
    input  logic        dat_ready,
    output logic [31:0] dat_data,
    output logic [3:0]  dat_strb,
    output logic        dat_last
);

    localparam int AW  = $clog2(CAP_BYTES);
    localparam int WAW = AW - 2;

    logic           wr_en;
    logic [AW-1:0]  wr_addr;
    logic [7:0]     wr_data;
    logic           done;
    rec_t           rec;
    logic           release_w;
    logic           busy;
    logic [WAW-1:0] rd_addr;
    logic [31:0]    rd_word;

    rsg_capture #(.CAP_BYTES(CAP_BYTES)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (rx_valid),
        .in_data      (rx_byte),
        .in_sof       (rx_sof),
        .in_eof       (rx_eof),
        .in_fcs_err   (rx_fcs_err),
        .in_other_err (rx_other_err),
        .release_i    (release_w),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .wr_data_o    (wr_data),
        .done_o       (done),
        .rec_o        (rec)
    );

    rsg_buffer #(.CAP_BYTES(CAP_BYTES)) u_buffer (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    rsg_emitter #(.CAP_BYTES(CAP_BYTES)) u_emitter (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (done),
        .rec_i       (rec),
        .rd_addr_o   (rd_addr),
        .rd_word_i   (rd_word),
        .sts_valid_o (sts_valid),
        .sts_ready_i (sts_ready),
        .sts_data_o  (sts_data),
        .sts_last_o  (sts_last),
        .dat_valid_o (dat_valid),
        .dat_ready_i (dat_ready),
        .dat_data_o  (dat_data),
        .dat_strb_o  (dat_strb),
        .dat_last_o  (dat_last),
        .release_o   (release_w),
        .busy_o      (busy)
    );

    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en) else $error("buffer written while draining"); // R10
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("record finished while draining"); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !sts_valid && !dat_valid) else $error("valid after reset"); // R11

endmodule

// File: tb/rx_status_gen_bench.sv
module rx_status_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 1024;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic        rx_fcs_err = 1'b0;
    logic        rx_other_err = 1'b0;
    logic        sts_valid, sts_last, dat_valid, dat_last;
    logic        sts_ready = 1'b0;
    logic        dat_ready = 1'b0;
    logic [31:0] sts_data, dat_data;
    logic [3:0]  dat_strb;

    int n_chk = 0;
    int n_fail = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [32:0] sts_q[$];
    logic [36:0] dat_q[$];
    int          sts_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_status_gen #(.CAP_BYTES(CAP)) u_rx_status_gen (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_fcs_err(rx_fcs_err),
        .rx_other_err(rx_other_err), .sts_valid(sts_valid), .sts_ready(sts_ready),
        .sts_data(sts_data), .sts_last(sts_last), .dat_valid(dat_valid),
        .dat_ready(dat_ready), .dat_data(dat_data), .dat_strb(dat_strb),
        .dat_last(dat_last)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // ready generation, changed just after the rising edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rdy_mode == 0) begin
            sts_ready = lfsr[1] | lfsr[4];
            dat_ready = lfsr[2] | lfsr[7];
        end else if (rdy_mode == 1) begin
            sts_ready = 1'b1;
            dat_ready = 1'b1;
        end
    end

    // scoreboard monitor, sampled on the falling edge
    logic        sts_stall = 1'b0, dat_stall = 1'b0;
    logic [32:0] sts_prev;
    logic [36:0] dat_prev;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sts_stall) chk(sts_valid && {sts_last, sts_data} == sts_prev, "R9 status stall",
                               {31'd0, sts_last, sts_data}, {31'd0, sts_prev});
            if (dat_stall) chk(dat_valid && {dat_last, dat_strb, dat_data} == dat_prev, "R9 data stall",
                               {27'd0, dat_last, dat_strb, dat_data}, {27'd0, dat_prev});
            sts_stall = sts_valid && !sts_ready;
            dat_stall = dat_valid && !dat_ready;
            sts_prev  = {sts_last, sts_data};
            dat_prev  = {dat_last, dat_strb, dat_data};
            if (sts_valid && sts_ready) begin
                logic [32:0] e;
                string t;
                case (sts_idx)
                    0: t = "R1 tag word";
                    1, 2: t = "R2 address word";
                    3: t = "R3 R4 flags word";
                    4: t = "R5 type word";
                    default: t = "R5 R6 tag/count word";
                endcase
                if (sts_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected status", {31'd0, sts_last, sts_data}, 64'd0);
                end else begin
                    e = sts_q.pop_front();
                    chk({sts_last, sts_data} == e, t, {31'd0, sts_last, sts_data}, {31'd0, e});
                end
                sts_idx = (sts_idx == 5) ? 0 : sts_idx + 1;
            end
            if (dat_valid && dat_ready) begin
                logic [36:0] e;
                chk(sts_q.size() == 0, "R8 data before record done", 64'(sts_q.size()), 64'd0);
                if (dat_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected data", {27'd0, dat_last, dat_strb, dat_data}, 64'd0);
                end else begin
                    e = dat_q.pop_front();
                    chk({dat_last, dat_strb, dat_data} == e, "R7 data word",
                        {27'd0, dat_last, dat_strb, dat_data}, {27'd0, e});
                end
            end
        end
    end

    function automatic logic [7:0] bget(input logic [7:0] fr[$], input int i);
        return (i < fr.size()) ? fr[i] : 8'h00;
    endfunction

    task automatic push_expect(input logic [7:0] fr[$], input bit fcs, input bit oth);
        int len, nb, nw;
        logic [47:0] dst;
        logic [31:0] w3;
        bit bad;
        len = (fr.size() > 16383) ? 16383 : fr.size();
        nb  = (len > CAP) ? CAP : len;
        for (int i = 0; i < 6; i++) dst[8*i +: 8] = bget(fr, i);
        bad = fcs | oth;
        w3 = 32'(len) << 11;
        w3[10] = dst[0];
        w3[9]  = &dst;
        w3[8]  = fcs;
        w3[7]  = bad;
        w3[6]  = !bad;
        sts_q.push_back({1'b0, 32'h5000_0000});
        sts_q.push_back({1'b0, 16'h0, dst[47:32]});
        sts_q.push_back({1'b0, dst[31:0]});
        sts_q.push_back({1'b0, w3});
        sts_q.push_back({1'b0, bget(fr, 12), bget(fr, 13), 16'h0});
        sts_q.push_back({1'b1, bget(fr, 14), bget(fr, 15), 16'(nb)});
        nw = (nb + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] d;
            logic [3:0]  s;
            bit          l;
            l = (w == nw - 1);
            d = '0;
            s = '0;
            for (int b = 0; b < 4; b++) begin
                if (4*w + b < nb) begin
                    d[8*b +: 8] = fr[4*w + b];
                    s[b] = 1'b1;
                end
            end
            dat_q.push_back({l, s, d});
        end
    endtask

    task automatic drive_frame(input logic [7:0] fr[$], input bit fcs, input bit oth, input bit use_sof);
        for (int i = 0; i < fr.size(); i++) begin
            @(posedge clk); #1;
            rx_valid     = 1'b1;
            rx_byte      = fr[i];
            rx_sof       = use_sof && (i == 0);
            rx_eof       = (i == fr.size() - 1);
            rx_fcs_err   = rx_eof ? fcs : 1'b0;
            rx_other_err = rx_eof ? oth : 1'b0;
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        rx_fcs_err = 1'b0; rx_other_err = 1'b0;
    endtask

    task automatic send(input logic [7:0] fr[$], input bit fcs, input bit oth);
        push_expect(fr, fcs, oth);
        drive_frame(fr, fcs, oth, 1'b1);
        wait_drain();
    endtask

    task automatic wait_drain();
        int guard = 0;
        while ((sts_q.size() != 0 || dat_q.size() != 0 || sts_valid || dat_valid) && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        chk(sts_q.size() == 0 && dat_q.size() == 0, "R1 R7 record and payload drained",
            64'(sts_q.size() + dat_q.size()), 64'd0);
    endtask

    function automatic void mk(ref logic [7:0] fr[$], input int n, input logic [7:0] seed);
        fr.delete();
        for (int i = 0; i < n; i++) fr.push_back(8'(seed + 8'(i * 7)));
    endfunction

    initial begin
        logic [7:0] fr[$];
        logic [7:0] fb[$];
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!sts_valid && !dat_valid, "R11 reset state", {62'd0, sts_valid, dat_valid}, 64'd0);

        // R2 address packing with a known unicast address, 20 bytes (R7 tail 0)
        fr = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        for (int i = 6; i < 20; i++) fr.push_back(8'(8'h60 + i));
        send(fr, 1'b0, 1'b0);

        // R7 tails of 1, 2, 3 bytes; R5 short frames with missing header bytes
        mk(fr, 17, 8'h02); send(fr, 1'b0, 1'b0);
        mk(fr, 14, 8'h10); send(fr, 1'b0, 1'b0);
        mk(fr, 15, 8'h20); send(fr, 1'b0, 1'b0);
        mk(fr, 3,  8'h40); send(fr, 1'b0, 1'b0);
        mk(fr, 1,  8'h51); send(fr, 1'b0, 1'b0);

        // R4 broadcast, multicast, error flag combinations
        mk(fr, 64, 8'h33);
        for (int i = 0; i < 6; i++) fr[i] = 8'hFF;
        send(fr, 1'b0, 1'b0);
        mk(fr, 60, 8'h01); fr[0] = 8'h01; send(fr, 1'b1, 1'b0);
        mk(fr, 61, 8'h02); send(fr, 1'b0, 1'b1);
        mk(fr, 62, 8'h05); send(fr, 1'b1, 1'b1);

        // R10 stray bytes with no start marker while idle
        mk(fb, 10, 8'h77);
        drive_frame(fb, 1'b0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk(!sts_valid && !dat_valid, "R10 bytes without start ignored", {62'd0, sts_valid, dat_valid}, 64'd0);

        // R8 R9 streams fully open, then throttled again
        rdy_mode = 1;
        mk(fr, 33, 8'h90); send(fr, 1'b0, 1'b0);
        rdy_mode = 0;

        // R10 start marker on the cycle the final data word is accepted
        rdy_mode = 2;
        sts_ready = 1'b1; dat_ready = 1'b0;
        mk(fr, 8, 8'hA0);
        push_expect(fr, 1'b0, 1'b0);
        drive_frame(fr, 1'b0, 1'b0, 1'b1);
        mk(fb, 18, 8'hC3);
        begin
            int guard = 0;
            forever begin
                @(posedge clk); #1;
                guard++;
                if ((dat_valid && dat_last) || guard > 1000) break;
                dat_ready = dat_valid;
            end
        end
        dat_ready = 1'b1;
        rx_valid = 1'b1; rx_byte = fb[0]; rx_sof = 1'b1; rx_eof = 1'b0;
        for (int i = 1; i < fb.size(); i++) begin
            @(posedge clk); #1;
            dat_ready = 1'b0;
            rx_sof = 1'b0; rx_byte = fb[i]; rx_eof = (i == fb.size() - 1);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_eof = 1'b0;
        repeat (20) @(negedge clk);
        chk(!sts_valid && sts_q.size() == 0 && dat_q.size() == 0, "R10 colliding start ignored",
            {63'd0, sts_valid}, 64'd0);
        rdy_mode = 0;
        mk(fr, 22, 8'hB4); send(fr, 1'b0, 1'b0);

        // R3 R6 length saturation and capacity limit
        mk(fr, 16390, 8'h0D); send(fr, 1'b0, 1'b0);
        // R6 frame exactly at capacity
        mk(fr, CAP, 8'h3E); send(fr, 1'b0, 1'b0);

        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        finish_run();
    end

endmodule